// File: doc/BRIEF.md
# Keyed Configuration Register Port

This block is a configuration register file reached through a pair of byte-wide I/O ports: an index port and, one address above it, a data port. Its registers stay hidden until the host writes a configured key byte to the index port on two index writes in a row. While the file is open, the host writes a register number to the index port and then reads or writes that register through the data port. Writing 0xAA to the index port closes the file again.

The register space has three parts. Fixed identification registers hold a vendor code and a chip code. A device selector picks one of several logical serial-port devices. Each device has its own bank, which holds a 16-bit I/O base address, an interrupt trigger setting and an RS-485 line control setting. Every bank's contents are driven onto output buses, so that the serial-port wrappers nearby can use them without going through the host.

Top module: `keyed_cfg_port`

## Requirements
- R1: The file opens only when two consecutive index-port writes both carry the KEY byte. A single key write does not open it. Any other index-port write between the two key writes restarts the count.
- R2: While the file is open, an index-port write of 0xAA closes it.
- R3: While the file is closed, data-port reads return 0xFF, and data-port writes change no register and no output bus.
- R4: The identification registers are read-only. Index 0x20 gives the chip code low byte and 0x21 gives the high byte. The default code is 0x1602 and 0x0501 is selectable by parameter. Index 0x23 gives 0x19 and index 0x24 gives 0x34. Writes to these registers change nothing.
- R5: Index 0x07 is the device selector and reads back its value. A write of a value from 0 to NDEV-1 takes effect. A write of NDEV or more is ignored.
- R6: In the selected device, index 0x60 is the high byte of the I/O base address and index 0x61 is the low byte. After reset, device n holds 0x03F8, 0x02F8, 0x03E8 or 0x02E8 for n mod 4 = 0, 1, 2 or 3.
- R7: In the selected device, index 0x70 is the interrupt setting. Bit 4 is the share enable. Bits 6:5 are the trigger mode, where 00 means level active-low and 01 means edge active-high. Only bits 6:4 are stored, the other bits read 0, and the register is 0 after reset.
- R8: In the selected device, index 0xF0 is the RS-485 control. Bit 5 inverts RTS, bit 4 enables automatic direction, bit 3 enables the receive-side wait delay and bit 2 enables the transmit-side wait delay. Only bits 5:2 are stored, the other bits read 0, and the register is 0 after reset.
- R9: Only addresses BASE_ADDR (index) and BASE_ADDR+1 (data) are decoded. Accesses to any other address change no state, and io_rdata reads 0x00 whenever no decoded read is under way.
- R10: A data-port read of an unmapped index returns 0x00. A data-port write to an unmapped index changes nothing.
- R11: dev_base, dev_irq_mode and dev_line_ctl carry device n's registers in slice n, with 16 bits per device for the base address and 8 bits per device for the other two.
- R12: An index-port read returns 0xFF while the file is closed and returns the current index while it is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the access |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid in the cycle io_rd is high |
| dev_base | output | NDEV*16 | I/O base address of each device |
| dev_irq_mode | output | NDEV*8 | Interrupt setting of each device |
| dev_line_ctl | output | NDEV*8 | RS-485 control of each device |

## Verification
The bench builds the block with KEY = 0xA0, BASE_ADDR = 0x002E and the alternative chip code 0x0501 rather than the defaults. This means the default port address 0x4E becomes an undecoded address that the bench can use to test the decode window. It also shows that the key, the port address and the chip code all come from parameters. With NDEV = 4, selector writes of 4 to 7 are the values that must be ignored, and the reset base addresses of all four devices can be seen at the ports.

// File: rtl/kcp_pkg.sv
package kcp_pkg;

    typedef enum logic [1:0] {
        LK_SHUT = 2'd0,
        LK_HALF = 2'd1,
        LK_OPEN = 2'd2
    } lock_e;

    localparam logic [7:0] EXIT_BYTE   = 8'hAA;
    localparam logic [7:0] IDX_LDN     = 8'h07;
    localparam logic [7:0] IDX_CHIP_LO = 8'h20;
    localparam logic [7:0] IDX_CHIP_HI = 8'h21;
    localparam logic [7:0] IDX_VEN_A   = 8'h23;
    localparam logic [7:0] IDX_VEN_B   = 8'h24;
    localparam logic [7:0] VEN_A_VAL   = 8'h19;
    localparam logic [7:0] VEN_B_VAL   = 8'h34;
    localparam logic [7:0] IDX_BASE_HI = 8'h60;
    localparam logic [7:0] IDX_BASE_LO = 8'h61;
    localparam logic [7:0] IDX_IRQ     = 8'h70;
    localparam logic [7:0] IDX_LINE    = 8'hF0;
    localparam logic [7:0] IRQ_MASK    = 8'h70;
    localparam logic [7:0] LINE_MASK   = 8'h3C;

    // Reset base address for device n (pattern repeats every four devices)
    function automatic logic [15:0] dflt_base(int unsigned n);
        logic [15:0] v;
        v = 16'h02E8;
        if ((n % 2) == 0)       v[8] = 1'b1;
        if (((n / 2) % 2) == 0) v[4] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/kcp_lock.sv
module kcp_lock
    import kcp_pkg::*;
#(
    parameter logic [7:0] KEY = 8'h87
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open_o
);

    typedef struct packed {
        lock_e st;
    } lock_t;

    lock_t lk_d, lk_q;

    always_comb begin
        lk_d = lk_q;
        if (idx_wr) begin
            unique case (lk_q.st)
                LK_SHUT: lk_d.st = (wdata == KEY) ? LK_HALF : LK_SHUT;
                LK_HALF: lk_d.st = (wdata == KEY) ? LK_OPEN : LK_SHUT;
                LK_OPEN: lk_d.st = (wdata == EXIT_BYTE) ? LK_SHUT : LK_OPEN;
                default: lk_d.st = LK_SHUT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_q <= '{st: LK_SHUT};
        else        lk_q <= lk_d;
    end

    assign open_o = (lk_q.st == LK_OPEN);

    // R1
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(idx_wr && (wdata == KEY)));

    // R1
    non_key_keeps_shut_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open_o && idx_wr && (wdata != KEY)) |=> !open_o);

    // R2
    exit_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && idx_wr && (wdata == EXIT_BYTE)) |=> !open_o);

endmodule

// File: rtl/kcp_bank.sv
module kcp_bank
    import kcp_pkg::*;
#(
    parameter logic [15:0] BASE_RST = 16'h03F8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  idx,
    input  logic [7:0]  wdata,
    output logic [15:0] base_o,
    output logic [7:0]  irq_o,
    output logic [7:0]  line_o
);

    typedef struct packed {
        logic [15:0] base;
        logic [7:0]  irq;
        logic [7:0]  line;
    } bank_t;

    bank_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (wr_en) begin
            unique case (idx)
                IDX_BASE_HI: bk_d.base[15:8] = wdata;
                IDX_BASE_LO: bk_d.base[7:0]  = wdata;
                IDX_IRQ:     bk_d.irq        = wdata & IRQ_MASK;
                IDX_LINE:    bk_d.line       = wdata & LINE_MASK;
                default:     bk_d            = bk_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bk_q <= '{base: BASE_RST, irq: 8'h00, line: 8'h00};
        else        bk_q <= bk_d;
    end

    assign base_o = bk_q.base;
    assign irq_o  = bk_q.irq;
    assign line_o = bk_q.line;

    // R3
    bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({base_o, irq_o, line_o}));

    // R10
    unmapped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx != IDX_BASE_HI && idx != IDX_BASE_LO && idx != IDX_IRQ
         && idx != IDX_LINE) |=> $stable({base_o, irq_o, line_o}));

endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
    import kcp_pkg::*;
#(
    parameter int unsigned NDEV      = 4,
    parameter logic [7:0]  KEY       = 8'h87,
    parameter logic [15:0] BASE_ADDR = 16'h004E,
    parameter logic [15:0] CHIP_ID   = 16'h1602
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [15:0]          io_addr,
    input  logic                 io_wr,
    input  logic                 io_rd,
    input  logic [7:0]           io_wdata,
    output logic [7:0]           io_rdata,
    output logic [NDEV*16-1:0]   dev_base,
    output logic [NDEV*8-1:0]    dev_irq_mode,
    output logic [NDEV*8-1:0]    dev_line_ctl
);

    localparam int unsigned LW = (NDEV > 1) ? $clog2(NDEV) : 1;

    typedef struct packed {
        logic [7:0]    idx;
        logic [LW-1:0] ldn;
    } ptr_t;

    ptr_t pt_d, pt_q;

    logic        open;
    logic        hit_idx, hit_dat;
    logic        idx_wr, dat_wr;
    logic [7:0]  rd_val;
    logic [15:0] base_arr [NDEV];
    logic [7:0]  irq_arr  [NDEV];
    logic [7:0]  line_arr [NDEV];

    assign hit_idx = (io_addr == BASE_ADDR);
    assign hit_dat = (io_addr == BASE_ADDR + 16'd1);
    assign idx_wr  = io_wr && hit_idx;
    assign dat_wr  = io_wr && hit_dat && open;

    kcp_lock #(.KEY(KEY)) u_lock (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (io_wdata),
        .open_o (open)
    );

    always_comb begin
        pt_d = pt_q;
        if (idx_wr && open && io_wdata != EXIT_BYTE)
            pt_d.idx = io_wdata;
        if (dat_wr && pt_q.idx == IDX_LDN && 32'(io_wdata) < NDEV)
            pt_d.ldn = io_wdata[LW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pt_q <= '{idx: 8'h00, ldn: '0};
        else        pt_q <= pt_d;
    end

    for (genvar g = 0; g < NDEV; g++) begin : g_bank
        kcp_bank #(.BASE_RST(dflt_base(g))) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (dat_wr && (pt_q.ldn == LW'(g))),
            .idx    (pt_q.idx),
            .wdata  (io_wdata),
            .base_o (base_arr[g]),
            .irq_o  (irq_arr[g]),
            .line_o (line_arr[g])
        );
        assign dev_base[g*16 +: 16]    = base_arr[g];
        assign dev_irq_mode[g*8 +: 8]  = irq_arr[g];
        assign dev_line_ctl[g*8 +: 8]  = line_arr[g];
    end

    always_comb begin
        unique case (pt_q.idx)
            IDX_CHIP_LO: rd_val = CHIP_ID[7:0];
            IDX_CHIP_HI: rd_val = CHIP_ID[15:8];
            IDX_VEN_A:   rd_val = VEN_A_VAL;
            IDX_VEN_B:   rd_val = VEN_B_VAL;
            IDX_LDN:     rd_val = 8'(pt_q.ldn);
            IDX_BASE_HI: rd_val = base_arr[pt_q.ldn][15:8];
            IDX_BASE_LO: rd_val = base_arr[pt_q.ldn][7:0];
            IDX_IRQ:     rd_val = irq_arr[pt_q.ldn];
            IDX_LINE:    rd_val = line_arr[pt_q.ldn];
            default:     rd_val = 8'h00;
        endcase
    end

    always_comb begin
        if (io_rd && hit_dat)      io_rdata = open ? rd_val : 8'hFF;
        else if (io_rd && hit_idx) io_rdata = open ? pt_q.idx : 8'hFF;
        else                       io_rdata = 8'h00;
    end

    // R5
    ldn_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && pt_q.idx == IDX_LDN && 32'(io_wdata) >= NDEV) |=> $stable(pt_q.ldn));

    // R9
    outside_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit_idx && !hit_dat) |=> $stable(pt_q));

    // R3
    shut_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && !idx_wr) |=> $stable(pt_q));

endmodule

// File: tb/sim_keyed_cfg_port.sv
`timescale 1ns/1ps
module sim_keyed_cfg_port;

    localparam int NDEV = 4;
    localparam logic [7:0]  KEY  = 8'hA0;
    localparam logic [15:0] BASE = 16'h002E;
    localparam logic [15:0] CHIP = 16'h0501;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h0;
    logic [7:0]  io_rdata;
    logic [NDEV*16-1:0] dev_base;
    logic [NDEV*8-1:0]  dev_irq_mode;
    logic [NDEV*8-1:0]  dev_line_ctl;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    int         m_lock;     // 0 shut, 1 half, 2 open
    logic [7:0] m_idx;
    int         m_ldn;
    logic [15:0] m_base [NDEV];
    logic [7:0]  m_irq  [NDEV];
    logic [7:0]  m_line [NDEV];

    always #4 clk = ~clk;   // 125 MHz

    keyed_cfg_port #(.NDEV(NDEV), .KEY(KEY), .BASE_ADDR(BASE), .CHIP_ID(CHIP)) u0 (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .dev_base(dev_base),
        .dev_irq_mode(dev_irq_mode), .dev_line_ctl(dev_line_ctl)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(logic [15:0] a);
        if (a == BASE + 16'd1) begin
            if (m_lock != 2) return 8'hFF;
            case (m_idx)
                8'h20: return CHIP[7:0];
                8'h21: return CHIP[15:8];
                8'h23: return 8'h19;
                8'h24: return 8'h34;
                8'h07: return 8'(m_ldn);
                8'h60: return m_base[m_ldn][15:8];
                8'h61: return m_base[m_ldn][7:0];
                8'h70: return m_irq[m_ldn];
                8'hF0: return m_line[m_ldn];
                default: return 8'h00;
            endcase
        end
        if (a == BASE) return (m_lock == 2) ? m_idx : 8'hFF;
        return 8'h00;
    endfunction

    task automatic model_write(logic [15:0] a, logic [7:0] d);
        if (a == BASE) begin
            if (m_lock == 2) begin
                if (d == 8'hAA) m_lock = 0;
                else m_idx = d;
            end else if (d == KEY) m_lock = m_lock + 1;
            else m_lock = 0;
        end else if (a == BASE + 16'd1 && m_lock == 2) begin
            case (m_idx)
                8'h07: if (d < NDEV) m_ldn = int'(d);
                8'h60: m_base[m_ldn][15:8] = d;
                8'h61: m_base[m_ldn][7:0] = d;
                8'h70: m_irq[m_ldn] = d & 8'h70;
                8'hF0: m_line[m_ldn] = d & 8'h3C;
                default: ;
            endcase
        end
    endtask

    task automatic check_buses(string req);
        logic [63:0] eb, ei, el;
        eb = '0; ei = '0; el = '0;
        for (int n = 0; n < NDEV; n++) begin
            eb[n*16 +: 16] = m_base[n];
            ei[n*8 +: 8]   = m_irq[n];
            el[n*8 +: 8]   = m_line[n];
        end
        check({req, " base"}, dev_base, eb);
        check({req, " irq"}, 64'(dev_irq_mode), ei);
        check({req, " line"}, 64'(dev_line_ctl), el);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(posedge clk);
        model_write(a, d);
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(string req, logic [15:0] a);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        #2;
        check(req, 64'(io_rdata), 64'(model_read(a)));
        @(posedge clk);
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic open_port();
        wr(BASE, KEY); wr(BASE, KEY);
    endtask

    task automatic sel(logic [7:0] i);
        wr(BASE, i);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pool [12];
        void'($urandom(32'd1234));
        m_lock = 0; m_idx = 8'h00; m_ldn = 0;
        for (int n = 0; n < NDEV; n++) begin
            m_base[n] = 16'h02E8 | ((n % 2 == 0) ? 16'h0100 : 16'h0) | (((n / 2) % 2 == 0) ? 16'h0010 : 16'h0);
            m_irq[n] = 8'h00; m_line[n] = 8'h00;
        end
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R6 R11 reset state
        @(negedge clk);
        check_buses("R6 R11 reset");
        check("R9 idle rdata", 64'(io_rdata), 64'h00);
        // R3 R12 closed reads
        rd("R3 closed data read", BASE + 16'd1);
        rd("R12 closed index read", BASE);
        // R1 single key, then interrupted sequence
        wr(BASE, KEY); rd("R1 single key", BASE + 16'd1);
        wr(BASE, 8'h55); wr(BASE, KEY); rd("R1 interrupted", BASE + 16'd1);
        wr(BASE, 8'h11);
        // R3 closed write ignored
        wr(BASE + 16'd1, 8'h5A); check_buses("R3 closed write");
        // R9 default port address is outside window here
        wr(16'h004E, KEY); wr(16'h004E, KEY); rd("R9 outside open", BASE);
        rd("R9 outside read", 16'h004F);
        open_port();
        rd("R12 open index read", BASE);
        // R4 ids
        sel(8'h20); rd("R4 chip lo", BASE + 16'd1);
        sel(8'h21); rd("R4 chip hi", BASE + 16'd1);
        wr(BASE + 16'd1, 8'hEE); rd("R4 read-only", BASE + 16'd1);
        sel(8'h23); rd("R4 vendor a", BASE + 16'd1);
        sel(8'h24); rd("R4 vendor b", BASE + 16'd1);
        check("R4 vendor b value", 64'(model_read(BASE + 16'd1)), 64'h34);
        // R5 selector
        sel(8'h07); wr(BASE + 16'd1, 8'h02); rd("R5 ldn 2", BASE + 16'd1);
        wr(BASE + 16'd1, 8'h04); rd("R5 ldn 4 ignored", BASE + 16'd1);
        wr(BASE + 16'd1, 8'hFF); rd("R5 ldn FF ignored", BASE + 16'd1);
        // R6 base
        sel(8'h60); wr(BASE + 16'd1, 8'h12);
        sel(8'h61); wr(BASE + 16'd1, 8'h34); rd("R6 base lo", BASE + 16'd1);
        check_buses("R6 R11 base write");
        // R7 irq, read-modify-write
        sel(8'h70); wr(BASE + 16'd1, 8'hFF); rd("R7 irq mask", BASE + 16'd1);
        wr(BASE + 16'd1, 8'h30); rd("R7 irq rmw", BASE + 16'd1);
        // R8 line
        sel(8'hF0); wr(BASE + 16'd1, 8'hFF); rd("R8 line mask", BASE + 16'd1);
        check_buses("R7 R8 R11 bank");
        // R10 unmapped
        sel(8'h55); wr(BASE + 16'd1, 8'h77); rd("R10 unmapped", BASE + 16'd1);
        check_buses("R10 unmapped write");
        // R2 exit
        wr(BASE, 8'hAA); rd("R2 closed after exit", BASE + 16'd1);
        wr(BASE + 16'd1, 8'h00); check_buses("R2 R3 write after exit");

        // constrained random mix
        pool = '{KEY, KEY, 8'hAA, 8'h07, 8'h20, 8'h21, 8'h23, 8'h60, 8'h61, 8'h70, 8'hF0, 8'h3C};
        for (int k = 0; k < 600; k++) begin
            int r;
            logic [15:0] a;
            r = int'($urandom % 10);
            a = (($urandom % 8) == 0) ? 16'h004F : BASE;
            if (m_lock != 2 && ($urandom % 3) == 0) open_port();
            if (r < 4) wr(a, pool[$urandom % 12]);
            else if (r < 7) wr(a + 16'd1, (m_idx == 8'h07) ? 8'($urandom % 8) : 8'($urandom));
            else rd("R1 R3 R5 R10 random read", a + ((r == 9) ? 16'd0 : 16'd1));
            if (k % 20 == 0) check_buses("R11 random buses");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule